// File: doc/BRIEF.md
# Vertex Attribute Fetch and Convert Unit

This unit gathers the input attributes of a single vertex ahead of a shader core. After a start pulse it visits attribute numbers from zero upward, up to a count taken from a 64-bit layout word. Each attribute is either fetched or defaulted. A fetched attribute reads one element per memory request, from an address built from the attribute's base address, its packed stride and the vertex number. Each raw element is turned into a 24-bit float. A defaulted attribute takes a stored four-component vector from an internal table, which is written through a plain write port, and issues no memory reads.

Each finished attribute leaves on a valid/ready output stream as a vector of four 24-bit floats, tagged with its attribute number. The output holds `out_valid`, `out_slot` and `out_vec` unchanged until `out_ready` is seen high at a clock edge. The read request channel follows the same rule: `rd_valid`, `rd_addr` and `rd_size` stay put until `rd_ready`. At most one read is outstanding. The memory answers a granted request with a single-cycle `rsp_valid` pulse at any later cycle. The unit is always able to take that response, so the response channel has no ready signal. A one-cycle `done` pulse ends each run. `layout`, `slot_base` and the default table must not change while a run is in progress.

Top module: `vtx_attr_fetch`

## Requirements
- R1: The number of attributes in a run is `layout[63:60]` + 1. They are emitted one per output handshake, in ascending number order starting at 0, and `out_slot` carries the attribute number.
- R2: Attribute n (n = 0 to 15) is defaulted when n >= 12 or `layout[48+n]` is 1. Its output vector is table entry n, and the unit issues no read request for it.
- R3: For a fetched attribute n below 12, the format code is `layout[4n+1:4n]` and the element count minus one is `layout[4n+3:4n+2]`. Format codes are 0 signed byte, 1 unsigned byte, 2 signed 16-bit and 3 float32, with element sizes 1, 1, 2 and 4 bytes. Element e is read at address base + count·size·vertex + e·size, modulo 2^32. Here base is `slot_base[32n+31:32n]`, and `rd_size` carries the format code.
- R4: Element reads are issued in ascending element order. A new request is raised only after the response to the previous one has arrived.
- R5: `rsp_data[7:0]` holds the byte at the requested address and higher bytes follow in order (little-endian). Formats 0 to 2 use the low 1 or 2 bytes, sign-extended for formats 0 and 2, and convert to the float24 of exactly the same numeric value. Integer zero gives all-zero bits.
- R6: Float24 layout is sign in bit 23, exponent in bits 22:16 with bias 63, mantissa in bits 15:0. A float32 with biased exponent E converts to exponent E−64 with the mantissa truncated to its top 16 bits. When E <= 64 the result is a signed zero (sign kept, other bits 0). When E >= 191 the result is the sign with all other bits 1.
- R7: Components beyond an attribute's element count are 0 for x, y and z and 0x3F0000 (1.0) for w. `out_vec` packs x in bits 23:0, y in 47:24, z in 71:48 and w in 95:72.
- R8: A stalled output (`out_valid` high and `out_ready` low) or a stalled request (`rd_valid` high and `rd_ready` low) holds its valid signal and its data unchanged into the next cycle.
- R9: `done` is high for exactly one cycle per run, in the cycle after the handshake of the last attribute.
- R10: `start` is ignored while a run is in progress. The run keeps its latched vertex number and emits exactly its own attribute count.
- R11: When `dflt_we` is high at a clock edge, `dflt_data` is stored into table entry `dflt_idx`. Reset clears every table entry to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run for `vertex` (taken only when idle) |
| vertex | input | 16 | Vertex number, latched at start |
| layout | input | 64 | Attribute layout word: slot fields, default mask, count |
| slot_base | input | 384 | Twelve 32-bit byte base addresses, slot n at bits 32n+31:32n |
| dflt_we | input | 1 | Default table write enable |
| dflt_idx | input | 4 | Default table entry to write |
| dflt_data | input | 96 | Default vector to store (same packing as `out_vec`) |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Memory accepts the request |
| rd_addr | output | 32 | Byte address of the element |
| rd_size | output | 2 | Format code of the element |
| rsp_valid | input | 1 | Read data valid (single-cycle pulse) |
| rsp_data | input | 32 | Little-endian read data |
| out_valid | output | 1 | Converted vector valid |
| out_ready | input | 1 | Consumer accepts the vector |
| out_slot | output | 4 | Attribute number of the vector |
| out_vec | output | 96 | Four float24 components, w highest |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
On every cycle the assertions check the handshake discipline: stalled requests and outputs hold their values, no request is raised while a read is outstanding, the slot number stays within the run's count, and `done` is a single-cycle pulse that follows the last output handshake. Whether the numbers are right can only be shown by the bench scenarios. That covers the computed addresses, the integer and float conversion corners (flush, saturation, extreme integers), the fill values, the choice of defaulted attributes and the table contents. The bench checks these against its own model under random back-pressure and random memory latency.

// File: rtl/vaf_pkg.sv
package vaf_pkg;

  typedef logic [23:0] f24_t;

  typedef enum logic [1:0] {
    FMT_S8  = 2'd0,
    FMT_U8  = 2'd1,
    FMT_S16 = 2'd2,
    FMT_F32 = 2'd3
  } elem_fmt_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PICK,
    ST_REQ,
    ST_WAIT,
    ST_EMIT
  } fetch_st_e;

  localparam f24_t F24_ZERO = 24'h000000;
  localparam f24_t F24_ONE  = 24'h3F0000;

  // log2 of the element size in bytes
  function automatic logic [1:0] fmt_shift(elem_fmt_e f);
    logic [1:0] s;
    case (f)
      FMT_F32: s = 2'd2;
      FMT_S16: s = 2'd1;
      default: s = 2'd0;
    endcase
    return s;
  endfunction

  // exact conversion of an integer magnitude up to 2^15
  function automatic f24_t int_to_f24(logic sgn, logic [15:0] mag);
    logic [3:0]  msb;
    logic [31:0] norm;
    f24_t        r;
    msb = '0;
    for (int i = 0; i < 16; i++) begin
      if (mag[i]) msb = 4'(i);
    end
    norm = {16'b0, mag} << (5'd16 - {1'b0, msb});
    if (mag == '0) r = F24_ZERO;
    else           r = {sgn, 7'd63 + {3'b0, msb}, norm[15:0]};
    return r;
  endfunction

  // truncating float32 -> float24 with flush and saturation
  function automatic f24_t f32_to_f24(logic [31:0] b);
    logic [7:0] e;
    logic [7:0] e_adj;
    f24_t       r;
    e     = b[30:23];
    e_adj = e - 8'd64;
    if (e <= 8'd64)       r = {b[31], 23'b0};
    else if (e >= 8'd191) r = {b[31], 7'h7F, 16'hFFFF};
    else                  r = {b[31], e_adj[6:0], b[22:7]};
    return r;
  endfunction

endpackage

// File: rtl/vaf_addr_gen.sv
module vaf_addr_gen
  import vaf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int VTX_W  = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  elem_fmt_e         fmt,
  input  logic [1:0]        cnt_m1,
  input  logic [VTX_W-1:0]  vtx,
  input  logic [1:0]        elem,
  output logic [ADDR_W-1:0] addr
);
  logic [1:0]        sh;
  logic [ADDR_W-1:0] stride;
  logic [ADDR_W-1:0] row_off;
  logic [ADDR_W-1:0] elem_off;

  always_comb begin
    sh       = fmt_shift(fmt);
    stride   = (ADDR_W'(cnt_m1) + ADDR_W'(1)) << sh;
    row_off  = stride * ADDR_W'(vtx);
    elem_off = ADDR_W'(elem) << sh;
    addr     = base + row_off + elem_off;
  end
endmodule

// File: rtl/vaf_convert.sv
module vaf_convert
  import vaf_pkg::*;
(
  input  elem_fmt_e   fmt,
  input  logic [31:0] raw,
  output f24_t        result
);
  logic [16:0] sval;
  logic [16:0] mag;
  logic        neg;

  always_comb begin
    case (fmt)
      FMT_S8:  sval = {{9{raw[7]}}, raw[7:0]};
      FMT_U8:  sval = {9'b0, raw[7:0]};
      default: sval = {raw[15], raw[15:0]};
    endcase
    neg = sval[16];
    mag = neg ? (~sval + 17'd1) : sval;
    if (fmt == FMT_F32) result = f32_to_f24(raw);
    else                result = int_to_f24(neg, mag[15:0]);
  end
endmodule

// File: rtl/vaf_dflt_table.sv
module vaf_dflt_table
  import vaf_pkg::*;
#(
  parameter int NUM_ATTR = 16,
  localparam int ATTR_W  = $clog2(NUM_ATTR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ATTR_W-1:0] wr_idx,
  input  logic [95:0]       wr_data,
  input  logic [ATTR_W-1:0] rd_idx,
  output logic [95:0]       rd_data
);
  logic [95:0] tbl_q [NUM_ATTR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ATTR; i++) tbl_q[i] <= '0;
    end else if (we) begin
      tbl_q[wr_idx] <= wr_data;
    end
  end

  assign rd_data = tbl_q[rd_idx];
endmodule

// File: rtl/vtx_attr_fetch.sv
module vtx_attr_fetch
  import vaf_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int VTX_W     = 16,
  parameter int NUM_SLOTS = 12,
  parameter int NUM_ATTR  = 16,
  localparam int ATTR_W   = $clog2(NUM_ATTR),
  localparam int MASK_LSB = 4 * NUM_SLOTS,
  localparam int CNT_LSB  = MASK_LSB + NUM_SLOTS,
  localparam int DESC_W   = CNT_LSB + ATTR_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [VTX_W-1:0]            vertex,
  input  logic [DESC_W-1:0]           layout,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slot_base,
  input  logic                        dflt_we,
  input  logic [ATTR_W-1:0]           dflt_idx,
  input  logic [95:0]                 dflt_data,
  output logic                        rd_valid,
  input  logic                        rd_ready,
  output logic [ADDR_W-1:0]           rd_addr,
  output logic [1:0]                  rd_size,
  input  logic                        rsp_valid,
  input  logic [31:0]                 rsp_data,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [ATTR_W-1:0]           out_slot,
  output logic [95:0]                 out_vec,
  output logic                        done
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);

  fetch_st_e          st_q;
  logic [ATTR_W-1:0]  attr_q;
  logic [1:0]         elem_q;
  logic [VTX_W-1:0]   vtx_q;
  f24_t [3:0]         vec_q;
  logic               done_q;

  logic [ADDR_W-1:0]  base_arr [NUM_SLOTS];
  logic               in_range;
  logic [SLOT_W-1:0]  slot_sel;
  elem_fmt_e          cur_fmt;
  logic [1:0]         cur_cnt_m1;
  logic               is_dflt;
  logic               last_attr;
  logic [95:0]        dflt_vec;
  f24_t               conv_val;
  logic [ADDR_W-1:0]  elem_addr;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_base
    assign base_arr[g] = slot_base[g*ADDR_W +: ADDR_W];
  end

  always_comb begin
    in_range   = int'(attr_q) < NUM_SLOTS;
    slot_sel   = in_range ? SLOT_W'(attr_q) : '0;
    cur_fmt    = elem_fmt_e'(layout[4*slot_sel +: 2]);
    cur_cnt_m1 = layout[4*slot_sel + 2 +: 2];
    is_dflt    = !in_range || layout[MASK_LSB + int'(slot_sel)];
    last_attr  = (attr_q == layout[CNT_LSB +: ATTR_W]);
  end

  vaf_addr_gen #(.ADDR_W(ADDR_W), .VTX_W(VTX_W)) u_addr (
    .base   (base_arr[slot_sel]),
    .fmt    (cur_fmt),
    .cnt_m1 (cur_cnt_m1),
    .vtx    (vtx_q),
    .elem   (elem_q),
    .addr   (elem_addr)
  );

  vaf_convert u_conv (
    .fmt    (cur_fmt),
    .raw    (rsp_data),
    .result (conv_val)
  );

  vaf_dflt_table #(.NUM_ATTR(NUM_ATTR)) u_dflt (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (dflt_we),
    .wr_idx  (dflt_idx),
    .wr_data (dflt_data),
    .rd_idx  (attr_q),
    .rd_data (dflt_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      attr_q <= '0;
      elem_q <= '0;
      vtx_q  <= '0;
      vec_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            vtx_q  <= vertex;
            attr_q <= '0;
            st_q   <= ST_PICK;
          end
        end
        ST_PICK: begin
          elem_q <= '0;
          if (is_dflt) begin
            vec_q <= dflt_vec;
            st_q  <= ST_EMIT;
          end else begin
            vec_q <= {F24_ONE, F24_ZERO, F24_ZERO, F24_ZERO};
            st_q  <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (rd_ready) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            vec_q[elem_q] <= conv_val;
            if (elem_q == cur_cnt_m1) begin
              st_q <= ST_EMIT;
            end else begin
              elem_q <= elem_q + 2'd1;
              st_q   <= ST_REQ;
            end
          end
        end
        ST_EMIT: begin
          if (out_ready) begin
            if (last_attr) begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              attr_q <= attr_q + 1'b1;
              st_q   <= ST_PICK;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_valid  = (st_q == ST_REQ);
  assign rd_addr   = elem_addr;
  assign rd_size   = cur_fmt;
  assign out_valid = (st_q == ST_EMIT);
  assign out_slot  = attr_q;
  assign out_vec   = vec_q;
  assign done      = done_q;
endmodule

// File: rtl/vaf_checker.sv
module vaf_checker #(
  parameter int ADDR_W  = 32,
  parameter int ATTR_W  = 4,
  parameter int DESC_W  = 64,
  parameter int CNT_LSB = 60
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DESC_W-1:0] layout,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [1:0]        rd_size,
  input logic              rsp_valid,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ATTR_W-1:0] out_slot,
  input logic [95:0]       out_vec,
  input logic              done
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  pend_q <= 1'b0;
    else if (rd_valid && rd_ready) pend_q <= 1'b1;
    else if (rsp_valid)          pend_q <= 1'b0;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr) && $stable(rd_size)); // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_vec) && $stable(out_slot)); // R8

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !pend_q); // R4

  AST_SLOT_IN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_slot <= layout[CNT_LSB +: ATTR_W]); // R1

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready && out_slot == layout[CNT_LSB +: ATTR_W])); // R9
endmodule

bind vtx_attr_fetch vaf_checker #(
  .ADDR_W (ADDR_W),
  .ATTR_W (ATTR_W),
  .DESC_W (DESC_W),
  .CNT_LSB(CNT_LSB)
) u_vaf_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .layout    (layout),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_addr   (rd_addr),
  .rd_size   (rd_size),
  .rsp_valid (rsp_valid),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_slot  (out_slot),
  .out_vec   (out_vec),
  .done      (done)
);

// File: tb/vtx_attr_fetch_test.sv
`timescale 1ns/1ps
module vtx_attr_fetch_test;
  localparam int NS = 12;
  localparam int NA = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [15:0]  vertex = '0;
  logic [63:0]  layout = '0;
  logic [NS*32-1:0] slot_base = '0;
  logic         dflt_we = 1'b0;
  logic [3:0]   dflt_idx = '0;
  logic [95:0]  dflt_data = '0;
  logic         rd_valid;
  logic         rd_ready = 1'b0;
  logic [31:0]  rd_addr;
  logic [1:0]   rd_size;
  logic         rsp_valid = 1'b0;
  logic [31:0]  rsp_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [3:0]   out_slot;
  logic [95:0]  out_vec;
  logic         done;

  always #10 clk = ~clk;

  vtx_attr_fetch uut (
    .clk(clk), .rst_n(rst_n), .start(start), .vertex(vertex), .layout(layout),
    .slot_base(slot_base), .dflt_we(dflt_we), .dflt_idx(dflt_idx), .dflt_data(dflt_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_size(rd_size),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_slot(out_slot), .out_vec(out_vec), .done(done)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0]  ovr [logic [31:0]];
  logic [95:0] dflt_sh [NA];
  logic [95:0] exp_vec [NA];
  logic [31:0] exp_addr [64];
  logic [1:0]  exp_size [64];
  int          n_exp_req, n_total;
  int          n_out, n_req, n_done;
  bit          run_fin, active;
  string       cur_tag;

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] mbyte(logic [31:0] a);
    logic [31:0] h;
    if (ovr.exists(a)) return ovr[a];
    h = a * 32'd2654435761;
    return h[20:13] ^ a[7:0];
  endfunction

  function automatic logic [31:0] mword(logic [31:0] a);
    return {mbyte(a + 32'd3), mbyte(a + 32'd2), mbyte(a + 32'd1), mbyte(a)};
  endfunction

  task automatic poke32(input logic [31:0] a, input logic [31:0] w);
    ovr[a] = w[7:0]; ovr[a+32'd1] = w[15:8]; ovr[a+32'd2] = w[23:16]; ovr[a+32'd3] = w[31:24];
  endtask

  // model of R6
  function automatic logic [23:0] m_f32(logic [31:0] b);
    int e;
    e = int'(b[30:23]);
    if (e <= 64) return {b[31], 23'd0};
    if (e >= 191) return {b[31], 23'h7FFFFF};
    return {b[31], 7'(e - 64), b[22:7]};
  endfunction

  // model of R5 via double precision
  function automatic logic [23:0] m_int(int v);
    logic [63:0] d;
    int          e;
    if (v == 0) return 24'd0;
    d = $realtobits(real'(v));
    e = int'(d[62:52]) - 960;
    return {d[63], 7'(e), d[51:36]};
  endfunction

  function automatic logic [23:0] m_conv(logic [1:0] f, logic [31:0] raw);
    case (f)
      2'd0: return m_int(int'($signed(raw[7:0])));
      2'd1: return m_int(int'(raw[7:0]));
      2'd2: return m_int(int'($signed(raw[15:0])));
      default: return m_f32(raw);
    endcase
  endfunction

  task automatic build_exp(input logic [15:0] vtx);
    n_total = int'(layout[63:60]) + 1;
    n_exp_req = 0;
    for (int a = 0; a < n_total; a++) begin
      if (a >= NS || layout[48+a]) begin
        exp_vec[a] = dflt_sh[a];
      end else begin
        logic [1:0]  f;
        int          cnt, sz;
        logic [23:0] c [4];
        f   = layout[4*a +: 2];
        cnt = int'(layout[4*a+2 +: 2]) + 1;
        sz  = (f == 2'd3) ? 4 : (f == 2'd2) ? 2 : 1;
        c[0] = 24'd0; c[1] = 24'd0; c[2] = 24'd0; c[3] = 24'h3F0000;
        for (int e = 0; e < cnt; e++) begin
          logic [31:0] ad;
          ad = slot_base[32*a +: 32] + 32'(cnt * sz) * 32'(vtx) + 32'(e * sz);
          exp_addr[n_exp_req] = ad;
          exp_size[n_exp_req] = f;
          n_exp_req++;
          c[e] = m_conv(f, mword(ad));
        end
        exp_vec[a] = {c[3], c[2], c[1], c[0]};
      end
    end
  endtask

  // memory model and output sink, all driven at the falling edge
  initial begin
    bit          pend = 0;
    int          dly = 0;
    logic [31:0] p_addr = '0;
    bit          o_stall = 0, r_stall = 0;
    logic [95:0] o_prev = '0;
    logic [3:0]  s_prev = '0;
    logic [33:0] r_prev = '0;
    forever begin
      @(negedge clk);
      if (active) begin
        bit rsp_now;
        if (o_stall) begin
          chk(out_valid && out_vec == o_prev && out_slot == s_prev, "R8 output hold",
              {out_valid, out_slot, out_vec[90:0]}, {1'b1, s_prev, o_prev[90:0]});
        end
        if (r_stall) begin
          chk(rd_valid && {rd_size, rd_addr} == r_prev, "R8 request hold",
              96'({rd_valid, rd_size, rd_addr}), 96'({1'b1, r_prev}));
        end
        rsp_valid = 1'b0;
        rsp_now   = 0;
        if (pend) begin
          if (dly == 0) begin
            rsp_valid = 1'b1;
            rsp_data  = mword(p_addr);
            pend      = 0;
            rsp_now   = 1;
          end else dly--;
        end
        rd_ready = ($urandom_range(0, 3) != 0);
        if (rd_valid && rd_ready) begin
          chk(!pend && !rsp_now, "R4 single outstanding read", 96'(pend), 96'(0));
          if (n_req < n_exp_req) begin
            chk({rd_size, rd_addr} == {exp_size[n_req], exp_addr[n_req]}, "R3 address/size",
                96'({rd_size, rd_addr}), 96'({exp_size[n_req], exp_addr[n_req]}));
          end else begin
            chk(0, "R2 unexpected read", 96'(rd_addr), 96'(0));
          end
          n_req++;
          pend   = 1;
          p_addr = rd_addr;
          dly    = $urandom_range(0, 3);
        end
        r_stall = rd_valid && !rd_ready;
        r_prev  = {rd_size, rd_addr};
        out_ready = ($urandom_range(0, 2) != 0);
        if (out_valid && out_ready) begin
          if (n_out < n_total) begin
            chk(out_slot == 4'(n_out), "R1 slot order", 96'(out_slot), 96'(n_out));
            chk(out_vec == exp_vec[n_out], cur_tag, out_vec, exp_vec[n_out]);
          end else begin
            chk(0, "R1 extra output", 96'(out_slot), 96'(n_total));
          end
          n_out++;
        end
        o_stall = out_valid && !out_ready;
        o_prev  = out_vec;
        s_prev  = out_slot;
        if (done) begin
          chk(n_out == n_total, "R9 done after last output", 96'(n_out), 96'(n_total));
          n_done++;
          run_fin = 1;
        end
      end
    end
  end

  task automatic run(input logic [63:0] lay, input logic [15:0] vtx, input string tag, input bit mid_start);
    layout = lay;
    vertex = vtx;
    build_exp(vtx);
    n_out = 0; n_req = 0; n_done = 0; run_fin = 0; cur_tag = tag;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (mid_start) begin
      repeat (6) @(negedge clk);
      start = 1'b1; vertex = vtx + 16'd1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!run_fin) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(n_out == n_total, "R1 output count", 96'(n_out), 96'(n_total));
    chk(n_req == n_exp_req, "R2 read count", 96'(n_req), 96'(n_exp_req));
    chk(n_done == 1, "R9 single done", 96'(n_done), 96'(1));
    if (mid_start) chk(n_out == n_total && n_req == n_exp_req, "R10 start ignored while busy",
                       96'(n_req), 96'(n_exp_req));
  endtask

  task automatic dflt_write(input logic [3:0] idx, input logic [95:0] v);
    @(negedge clk);
    dflt_we = 1'b1; dflt_idx = idx; dflt_data = v;
    @(negedge clk);
    dflt_we = 1'b0;
    dflt_sh[idx] = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NA; i++) dflt_sh[i] = '0;
    repeat (4) @(negedge clk);
    chk(!out_valid && !rd_valid && !done, "R9 reset outputs idle",
        96'({out_valid, rd_valid, done}), 96'(0));
    rst_n = 1'b1;
    active = 1;

    // table cleared by reset; every attribute defaulted
    run(64'hFFFF_0000_0000_0000, 16'd7, "R11 R2 reset table", 0);
    for (int i = 0; i < NA; i++)
      dflt_write(4'(i), {$urandom(), $urandom(), $urandom()});
    run(64'hFFFF_0000_0000_0000, 16'd9, "R11 R2 written table", 0);

    // defaults forced above slot 11 plus mask picks
    slot_base = {12{$urandom()}};
    run(64'hD5A5_0000_9C7F_6A3D, 16'd2, "R2 R3 mixed", 0);

    // conversion corners, with a stray start mid run
    slot_base = '0;
    slot_base[0*32 +: 32] = 32'h1000;
    slot_base[1*32 +: 32] = 32'h1100;
    slot_base[2*32 +: 32] = 32'h2000;
    slot_base[3*32 +: 32] = 32'h2100;
    slot_base[4*32 +: 32] = 32'h2200;
    poke32(32'h1000, 32'h3F800000);
    poke32(32'h1004, 32'h7F000000);
    poke32(32'h1008, 32'h20000000);
    poke32(32'h100C, 32'hC0200000);
    poke32(32'h1100, 32'h20800000);
    poke32(32'h1104, 32'h5F7FFFFF);
    poke32(32'h2000, 32'h00FF7F80);
    poke32(32'h2100, 32'h000100FF);
    poke32(32'h2200, 32'h7FFF8000);
    run(64'h4000_0000_0006_9C7F, 16'd0, "R5 R6 R7 corners", 1);
    chk(exp_vec[0][47:24] == 24'h7FFFFF && exp_vec[0][71:48] == 24'h0, "R6 model corner",
        exp_vec[0], exp_vec[0]);
    run(64'h4000_0000_0006_9C7F, 16'd3, "R3 R5 strided vertex", 0);

    for (int r = 0; r < 30; r++) begin
      logic [63:0] lay;
      for (int s = 0; s < NS; s++) slot_base[32*s +: 32] = $urandom();
      lay = {$urandom(), $urandom()};
      run(lay, 16'($urandom()), "R3 R5 R6 R7 random", 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule